// File: doc/BRIEF.md
# Strobed Wake-Up Interval Timer

This block combines a register interface on the processor side with a 16-bit wake-up down-counter on the side that stays powered. Software writes a control byte and two interval bytes. Nothing it writes reaches the powered side until it raises a software-driven SET bit. On that rising edge, the run enable, the two general-purpose bits, the wake flag request and the interval all move across together. LOAD can also be set in the same transfer to restart the counter from the new interval.

While it runs, the counter steps down once per tick of a selected timebase. The timebase is a slow tick normally and a fast tick in test mode. When the count expires, the counter latches a wake flag and reloads itself. Two cycles after each transfer, a completion flag tells software that new settings are accepted. Reads of the flags return the copies held on the powered side. The interrupt request combines both flags with an enable and a standby-permission input.

The design uses one clock. The powered-side registers are a separate group of state that changes only on a transfer, on a timebase tick, or by hardware flag setting.

Top module: `wake_interval_timer`

## Requirements
- R1: Register map. Address 0x94 is control, 0x95 is the interval low byte (bits 7..0) and 0x96 is the interval high byte (bits 15..8). Control bits from bit 7 down to bit 0 are RUN, WUP, TEST, CPL, Z1, Z0, LOAD, SET. Reads of RUN, TEST, LOAD, SET and both interval bytes return the written values. Any other address reads 0 and ignores writes.
- R2: A control write that takes SET from 0 to 1 at clock edge W updates the powered-side RUN, Z1/Z0, WUP and reload latch at edge W+1. The values used are those held after edge W. No other write changes these copies.
- R3: If LOAD is 1 at the transfer, the counter is loaded at edge W+1 with the new 16-bit interval. A load takes precedence over counting at that edge.
- R4: While the powered-side RUN is 1, each selected tick applies one step. A count of 0 or 1 sets WUP and reloads from the reload latch; any other count decrements by one. An interval of N (N ≥ 1) therefore sets WUP on the N-th tick. While RUN is 0, the count holds.
- R5: TEST=1 selects `tick_fast` as the timebase; TEST=0 selects `tick_slow`.
- R6: Bit 6 of a control read returns the powered-side WUP. A transfer copies the written WUP value into it, which either sets or clears it. An expiry on the same edge sets it regardless.
- R7: CPL reads 1 after edge W+2 of each transfer. Writing 0 to bit 4 clears it and writing 1 has no effect. The hardware set wins on a collision.
- R8: Bits 3:2 of a control read return the powered-side Z1/Z0 copies.
- R9: `irq` = (WUP & `wake_ie` & `stby_ok`) | (CPL & `wake_ie`).
- R10: After reset, all registers, copies and the counter are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Primary reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| tick_slow | input | 1 | Normal timebase tick |
| tick_fast | input | 1 | Test timebase tick |
| wake_ie | input | 1 | Wake-up interrupt enable |
| stby_ok | input | 1 | Standby-allowed condition |
| irq | output | 1 | Interrupt request |

## Verification
Processor-side fields can be read back one edge after their write. Powered-side copies and a LOAD change one edge after the SET rising edge, that is two edges after the write, and CPL changes one edge later again. A timebase tick shows up in WUP at the edge on which it is sampled. The bench changes inputs on the falling edge and compares `rdata` and `irq` shortly after it. A reference model advanced on every rising edge with these exact latencies supplies the expected values. Directed sequences also check the literal cycle in which CPL and WUP first appear.

// File: rtl/wake_interval_timer.sv
module wake_interval_timer #(
  parameter logic [7:0] A_CTRL = 8'h94,
  parameter logic [7:0] A_LO   = 8'h95,
  parameter logic [7:0] A_HI   = 8'h96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick_slow,
  input  logic       tick_fast,
  input  logic       wake_ie,
  input  logic       stby_ok,
  output logic       irq
);
  localparam int CW = 16;

  logic          run_w, wup_w, test_w, load_w, set_w, set_prev, pend_q, cpl_q;
  logic [1:0]    z_w, z_a;
  logic [7:0]    lo_w, hi_w;
  logic          run_a, wup_a;
  logic [CW-1:0] rel_a, cnt_a;

  wire wr_ctrl  = wr_en && addr == A_CTRL;
  wire set_rise = set_w & ~set_prev;
  wire tick_sel = test_w ? tick_fast : tick_slow;
  wire step     = run_a & tick_sel;
  wire expire   = step && cnt_a <= CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run_w, wup_w, test_w, load_w, set_w, set_prev, pend_q, cpl_q} <= '0;
      z_w  <= '0;
      lo_w <= '0;
      hi_w <= '0;
    end else begin
      set_prev <= set_w;
      pend_q   <= set_rise;
      if (wr_ctrl) begin
        run_w  <= wdata[7];
        wup_w  <= wdata[6];
        test_w <= wdata[5];
        z_w    <= wdata[3:2];
        load_w <= wdata[1];
        set_w  <= wdata[0];
      end
      if (wr_en && addr == A_LO) lo_w <= wdata;
      if (wr_en && addr == A_HI) hi_w <= wdata;
      if (pend_q)                    cpl_q <= 1'b1;
      else if (wr_ctrl && !wdata[4]) cpl_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= 1'b0;
      wup_a <= 1'b0;
      z_a   <= '0;
      rel_a <= '0;
      cnt_a <= '0;
    end else begin
      if (set_rise) begin
        run_a <= run_w;
        z_a   <= z_w;
        rel_a <= {hi_w, lo_w};
        wup_a <= wup_w | expire;
      end else if (expire) begin
        wup_a <= 1'b1;
      end
      if (set_rise && load_w) cnt_a <= {hi_w, lo_w};
      else if (step)          cnt_a <= expire ? rel_a : cnt_a - CW'(1);
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {run_w, wup_a, test_w, cpl_q, z_a, load_w, set_w};
      A_LO:    rdata = lo_w;
      A_HI:    rdata = hi_w;
      default: rdata = '0;
    endcase
  end

  assign irq = (wup_a & wake_ie & stby_ok) | (cpl_q & wake_ie);
endmodule

module wake_interval_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        set_rise,
  input logic        cpl_q,
  input logic        run_a,
  input logic        tick_sel,
  input logic [15:0] cnt_a,
  input logic        wup_a,
  input logic [1:0]  z_a,
  input logic        wake_ie,
  input logic        irq
);
  assert_cpl_after_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_q) |-> $past(set_rise, 2));
  assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !set_rise) |=> $stable(cnt_a));
  assert_run_copy_only_on_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_rise |=> $stable(run_a));
  assert_z_copy_only_on_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_rise |=> $stable(z_a));
  assert_wup_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wup_a) |-> ($past(set_rise) || $past(run_a && tick_sel)));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_ie |-> !irq);
endmodule

bind wake_interval_timer wake_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_rise(set_rise), .cpl_q(cpl_q), .run_a(run_a),
  .tick_sel(tick_sel), .cnt_a(cnt_a), .wup_a(wup_a), .z_a(z_a),
  .wake_ie(wake_ie), .irq(irq)
);

// File: tb/wake_interval_timer_bench.sv
`timescale 1ns/1ps
module wake_interval_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tick_slow = 1'b0, tick_fast = 1'b0, wake_ie = 1'b0, stby_ok = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;
  int vecs = 0, bad = 0;

  always #2.5 clk = ~clk;

  wake_interval_timer u_wake_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .wake_ie(wake_ie), .stby_ok(stby_ok),
    .irq(irq));

  logic m_run, m_wup, m_test, m_load, m_set, m_setp, m_pend, m_cpl, m_run_a, m_wup_a;
  logic [1:0] m_z, m_z_a;
  logic [7:0] m_lo, m_hi;
  logic [15:0] m_rel, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_run, m_wup, m_test, m_load, m_set, m_setp, m_pend, m_cpl, m_run_a, m_wup_a} = '0;
      m_z = '0; m_z_a = '0; m_lo = '0; m_hi = '0; m_rel = '0; m_cnt = '0;
    end else begin
      logic rise, tk, ex, cpl_n, wup_n;
      logic [15:0] cnt_n;
      rise  = m_set && !m_setp;
      tk    = m_run_a && (m_test ? tick_fast : tick_slow);
      ex    = tk && m_cnt <= 16'd1;
      cpl_n = m_pend ? 1'b1 : (wr_en && addr == 8'h94 && !wdata[4]) ? 1'b0 : m_cpl;
      wup_n = ex ? 1'b1 : rise ? m_wup : m_wup_a;
      cnt_n = (rise && m_load) ? {m_hi, m_lo} : tk ? (ex ? m_rel : m_cnt - 16'd1) : m_cnt;
      if (rise) begin m_run_a = m_run; m_z_a = m_z; m_rel = {m_hi, m_lo}; end
      m_wup_a = wup_n; m_cnt = cnt_n; m_cpl = cpl_n;
      m_pend = rise; m_setp = m_set;
      if (wr_en && addr == 8'h94) {m_run, m_wup, m_test, m_z, m_load, m_set} =
          {wdata[7:5], wdata[3:0]};
      if (wr_en && addr == 8'h95) m_lo = wdata;
      if (wr_en && addr == 8'h96) m_hi = wdata;
    end
  end

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h94:   return {m_run, m_wup_a, m_test, m_cpl, m_z_a, m_load, m_set};
      8'h95:   return m_lo;
      8'h96:   return m_hi;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e;
    e = m_read(addr);
    if (addr == 8'h94) begin
      check("R6 wake flag", {7'd0, rdata[6]}, {7'd0, e[6]});
      check("R7 completion", {7'd0, rdata[4]}, {7'd0, e[4]});
      check("R8 general bits", {6'd0, rdata[3:2]}, {6'd0, e[3:2]});
      check("R1 control fields", rdata & 8'hA3, e & 8'hA3);
    end else begin
      check("R1 register read", rdata, e);
    end
    check("R9 irq", {7'd0, irq}, {7'd0, (m_wup_a & wake_ie & stby_ok) | (m_cpl & wake_ie)});
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d,
                     input logic ts, input logic tf);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick_slow = ts; tick_fast = tf;
    #1 compare_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1D5EED));
    wake_ie = 1'b1; stby_ok = 1'b1;
    #12 @(negedge clk);
    check("R10 reset ctrl", rdata, 8'h00);
    check("R10 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(1, 8'h95, 8'h03, 0, 0);
    cyc(1, 8'h96, 8'h00, 0, 0);
    cyc(1, 8'h94, 8'h82, 0, 0);
    cyc(1, 8'h94, 8'h83, 0, 0);
    cyc(0, 8'h94, 8'h00, 0, 0); check("R7 cpl not yet", {7'd0, rdata[4]}, 8'h00);
    cyc(0, 8'h94, 8'h00, 0, 0); check("R7 cpl not yet", {7'd0, rdata[4]}, 8'h00);
    cyc(0, 8'h94, 8'h00, 1, 0); check("R7 cpl at W+2", {7'd0, rdata[4]}, 8'h01);
    cyc(0, 8'h94, 8'h00, 1, 0); check("R3 loaded no wake", {7'd0, rdata[6]}, 8'h00);
    cyc(0, 8'h94, 8'h00, 1, 0); check("R4 no wake after 2 ticks", {7'd0, rdata[6]}, 8'h00);
    cyc(0, 8'h94, 8'h00, 0, 0); check("R4 wake on 3rd tick", {7'd0, rdata[6]}, 8'h01);
    cyc(0, 8'h94, 8'h00, 0, 1); check("R5 fast tick ignored", {7'd0, rdata[6]}, 8'h01);
    cyc(1, 8'h94, 8'h8C, 0, 0);
    cyc(1, 8'h94, 8'h8D, 0, 0);
    cyc(0, 8'h94, 8'h00, 0, 0);
    cyc(0, 8'h94, 8'h00, 0, 0);
    check("R6 wup cleared by SET", {7'd0, rdata[6]}, 8'h00);
    check("R8 z copies", {6'd0, rdata[3:2]}, 8'h03);
    cyc(1, 8'h90, 8'hFF, 0, 0);
    cyc(0, 8'h90, 8'h00, 0, 0); check("R1 unmapped read", rdata, 8'h00);
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] a, d;
      r = int'($urandom_range(0, 9));
      wake_ie = ($urandom_range(0, 7) != 0);
      stby_ok = $urandom_range(0, 1) == 1;
      if (r < 3) begin
        a = 8'h94;
        d = 8'($urandom);
        if ($urandom_range(0, 3) == 0) d[5] = 1'b0;
      end else if (r == 3) begin a = 8'h95; d = 8'($urandom_range(0, 9)); end
      else if (r == 4) begin a = 8'h96; d = ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00; end
      else begin a = 8'($urandom_range(8'h93, 8'h97)); d = 8'($urandom); end
      cyc(r < 6, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
    end
    summary();
  end
endmodule